// File: doc/BRIEF.md
# Shared-Memory Mailbox Interrupt Unit

This block sits beside a memory that two agents, called left and right, reach through separate access ports. It does not hold any data. It watches the address and control lines of both ports and keeps one interrupt flag for each side. The two highest words of the address space act as mailboxes. The very top word belongs to the right side, and the word just below it belongs to the left side.

A write by one side into the other side's mailbox raises an interrupt toward the owner. The owner takes the interrupt down by reading its own mailbox. Every control input is active high and sampled on the rising clock edge. The two interrupt outputs are active low. The block has no data stream, so it has no valid/ready interface and applies no back-pressure. All pins are plain level signals, sampled once per clock.

The address width is a parameter, and both mailbox addresses are derived from it.

Top module: `mbx_irq_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, both `lt_irq_n` and `rt_irq_n` are high.
- R2: The right mailbox is the all-ones address. A left-port write there (`lt_sel`=1, `lt_wr`=1) drives `rt_irq_n` low from the clock edge that samples it. `rt_irq_n` then stays low until it is cleared.
- R3: The left mailbox is the all-ones address minus one. A right-port write there drives `lt_irq_n` low from the clock edge that samples it. `lt_irq_n` then stays low until it is cleared.
- R4: The owner reading its own mailbox (`sel`=1, `wr`=0, `rd_en`=1) drives that owner's interrupt high at the sampling edge.
- R5: A port writing its own mailbox does not lower its own interrupt output.
- R6: The non-owning port reading a mailbox does not release the owner's interrupt.
- R7: A set and a clear of the same flag in the same cycle leave the interrupt asserted (low).
- R8: The flags are not affected by writes to any other address, or by a write strobe given while the select is low.
- R9: An owner access with `sel`=1 and `wr`=0 but `rd_en`=0 does not clear the interrupt.
- R10: The mailbox addresses follow `ADDR_W`. At 14 bits, only address 0x3FFF raises the right-side interrupt, and address 0x0FFF has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lt_addr | input | ADDR_W | Left port address |
| lt_sel | input | 1 | Left port select |
| lt_wr | input | 1 | Left port write strobe |
| lt_rd_en | input | 1 | Left port read (output) enable |
| rt_addr | input | ADDR_W | Right port address |
| rt_sel | input | 1 | Right port select |
| rt_wr | input | 1 | Right port write strobe |
| rt_rd_en | input | 1 | Right port read (output) enable |
| lt_irq_n | output | 1 | Left interrupt, active low |
| rt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The stimulus is a sequence of cycles, and each one is chosen to tell one cause from another:
- cross writes against own writes, to separate the set path from address matching alone;
- owner reads against non-owner reads and reads with the enable low, so a clear that ignores the port or the enable is exposed;
- concurrent set and clear, to pin down the priority;
- writes to unrelated addresses and strobes without select.

A second instance at 14 bits shows that the mailbox decode tracks the parameter rather than a fixed 12-bit value. A reset in the middle of operation confirms that the flags return high.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;
  localparam int unsigned N_PORTS = 2;
  localparam int unsigned LT = 0;
  localparam int unsigned RT = 1;

  typedef struct packed {
    logic sel;
    logic wr;
    logic rd_en;
  } port_ctl_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]  addr,
  input  port_ctl_t          ctl,
  output logic [N_PORTS-1:0] wr_hit,
  output logic [N_PORTS-1:0] rd_hit
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  for (genvar m = 0; m < N_PORTS; m++) begin : g_mbx
    localparam logic [ADDR_W-1:0] MBX_ADDR =
      (m == RT) ? TOP_ADDR : TOP_ADDR - ADDR_W'(1);
    logic match;
    assign match     = ctl.sel && (addr == MBX_ADDR);
    assign wr_hit[m] = match && ctl.wr;
    assign rd_hit[m] = match && !ctl.wr && ctl.rd_en;
  end
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
  import mbx_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              lt_sel,
  input  logic              lt_wr,
  input  logic              lt_rd_en,
  input  logic [ADDR_W-1:0] rt_addr,
  input  logic              rt_sel,
  input  logic              rt_wr,
  input  logic              rt_rd_en,
  output logic              lt_irq_n,
  output logic              rt_irq_n
);
  localparam logic [ADDR_W-1:0] RT_MBX = '1;
  localparam logic [ADDR_W-1:0] LT_MBX = RT_MBX - ADDR_W'(1);

  logic [ADDR_W-1:0]  p_addr [N_PORTS];
  port_ctl_t          p_ctl  [N_PORTS];
  logic [N_PORTS-1:0] wr_hit [N_PORTS];
  logic [N_PORTS-1:0] rd_hit [N_PORTS];
  logic [N_PORTS-1:0] flag_q;

  assign p_addr[LT] = lt_addr;
  assign p_addr[RT] = rt_addr;
  assign p_ctl[LT]  = '{sel: lt_sel, wr: lt_wr, rd_en: lt_rd_en};
  assign p_ctl[RT]  = '{sel: rt_sel, wr: rt_wr, rd_en: rt_rd_en};

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    mbx_port_decode #(.ADDR_W(ADDR_W)) dec_i (
      .addr   (p_addr[p]),
      .ctl    (p_ctl[p]),
      .wr_hit (wr_hit[p]),
      .rd_hit (rd_hit[p])
    );
  end

  // Flag m is set by the other port writing mailbox m and cleared by port m reading it.
  for (genvar m = 0; m < N_PORTS; m++) begin : g_flag
    localparam int unsigned OTHER = N_PORTS - 1 - m;
    mbx_irq_flag flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wr_hit[OTHER][m]),
      .clr   (rd_hit[m][m]),
      .flag  (flag_q[m])
    );
  end

  assign lt_irq_n = ~flag_q[LT];
  assign rt_irq_n = ~flag_q[RT];

  // R5
  own_write_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_irq_n && lt_sel && lt_wr && lt_addr == LT_MBX &&
     !(rt_sel && rt_wr && rt_addr == LT_MBX)) |=> lt_irq_n);

  // R5
  own_write_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_irq_n && rt_sel && rt_wr && rt_addr == RT_MBX &&
     !(lt_sel && lt_wr && lt_addr == RT_MBX)) |=> rt_irq_n);

  // R6
  keep_lt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lt_irq_n && !(lt_sel && !lt_wr && lt_rd_en && lt_addr == LT_MBX))
      |=> !lt_irq_n);

  // R6
  keep_rt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rt_irq_n && !(rt_sel && !rt_wr && rt_rd_en && rt_addr == RT_MBX))
      |=> !rt_irq_n);

  // R2
  rt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lt_sel && lt_wr && lt_addr == RT_MBX) |=> !rt_irq_n);

  // R3
  lt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rt_sel && rt_wr && rt_addr == LT_MBX) |=> !lt_irq_n);
endmodule

// File: tb/mbx_irq_unit_tb_top.sv
module mbx_irq_unit_tb_top;
  localparam int unsigned AW   = 12;
  localparam int unsigned AW14 = 14;
  localparam int unsigned NVEC = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_sel = 0, lt_wr = 0, lt_rd_en = 0;
  logic rt_sel = 0, rt_wr = 0, rt_rd_en = 0;
  logic lt_irq_n, rt_irq_n;

  logic [AW14-1:0] w_lt_addr = '0, w_rt_addr = '0;
  logic w_lt_sel = 0, w_lt_wr = 0;
  logic w_lt_irq_n, w_rt_irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  mbx_irq_unit #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .lt_addr(lt_addr), .lt_sel(lt_sel), .lt_wr(lt_wr), .lt_rd_en(lt_rd_en),
    .rt_addr(rt_addr), .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_rd_en(rt_rd_en),
    .lt_irq_n(lt_irq_n), .rt_irq_n(rt_irq_n)
  );

  mbx_irq_unit #(.ADDR_W(AW14)) dut14_i (
    .clk(clk), .rst_n(rst_n),
    .lt_addr(w_lt_addr), .lt_sel(w_lt_sel), .lt_wr(w_lt_wr), .lt_rd_en(1'b0),
    .rt_addr(w_rt_addr), .rt_sel(1'b0), .rt_wr(1'b0), .rt_rd_en(1'b0),
    .lt_irq_n(w_lt_irq_n), .rt_irq_n(w_rt_irq_n)
  );

  // Field layout: {req[3:0], la[1:0], ls, lw, lo, ra[1:0], rs, rw, ro, exp_lt_n, exp_rt_n}
  // Address code: 0 = 0x123, 1 = left mailbox, 2 = right mailbox
  localparam logic [15:0] VEC [NVEC] = '{
    {4'd2,  2'd2, 3'b110, 2'd0, 3'b000, 2'b10}, // R2 left writes right mailbox
    {4'd2,  2'd0, 3'b000, 2'd0, 3'b000, 2'b10}, // R2 flag held while idle
    {4'd9,  2'd0, 3'b000, 2'd2, 3'b100, 2'b10}, // R9 owner read without enable
    {4'd6,  2'd2, 3'b101, 2'd0, 3'b000, 2'b10}, // R6 non-owner read
    {4'd4,  2'd0, 3'b000, 2'd2, 3'b101, 2'b11}, // R4 owner read clears
    {4'd3,  2'd0, 3'b000, 2'd1, 3'b110, 2'b01}, // R3 right writes left mailbox
    {4'd5,  2'd0, 3'b000, 2'd2, 3'b110, 2'b01}, // R5 right writes own mailbox
    {4'd8,  2'd0, 3'b110, 2'd0, 3'b000, 2'b01}, // R8 write elsewhere
    {4'd7,  2'd1, 3'b101, 2'd1, 3'b110, 2'b01}, // R7 set and clear together
    {4'd4,  2'd1, 3'b101, 2'd0, 3'b000, 2'b11}, // R4 left owner read clears
    {4'd8,  2'd2, 3'b010, 2'd0, 3'b000, 2'b11}, // R8 strobe without select
    {4'd3,  2'd2, 3'b110, 2'd1, 3'b110, 2'b00}, // R3 cross writes together
    {4'd4,  2'd1, 3'b101, 2'd2, 3'b101, 2'b11}, // R4 both owners read
    {4'd5,  2'd1, 3'b110, 2'd0, 3'b000, 2'b11}  // R5 left writes own mailbox
  };

  function automatic logic [AW-1:0] code_addr(input logic [1:0] c);
    case (c)
      2'd1:    return {AW{1'b1}} - AW'(1);
      2'd2:    return {AW{1'b1}};
      default: return AW'(12'h123);
    endcase
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle_ports();
    lt_sel = 0; lt_wr = 0; lt_rd_en = 0;
    rt_sel = 0; rt_wr = 0; rt_rd_en = 0;
    w_lt_sel = 0; w_lt_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 during reset
    #15;
    chk("R1 lt in reset", lt_irq_n, 1'b1);
    chk("R1 rt in reset", rt_irq_n, 1'b1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #5;
    chk("R1 lt after release", lt_irq_n, 1'b1);
    chk("R1 rt after release", rt_irq_n, 1'b1);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      lt_addr = code_addr(VEC[i][11:10]);
      {lt_sel, lt_wr, lt_rd_en} = VEC[i][9:7];
      rt_addr = code_addr(VEC[i][6:5]);
      {rt_sel, rt_wr, rt_rd_en} = VEC[i][4:2];
      @(posedge clk); #5;
      checks++;
      if (lt_irq_n !== VEC[i][1] || rt_irq_n !== VEC[i][0]) begin
        fails++;
        $display("FAIL R%0d vector %0d: actual lt=%b rt=%b expected lt=%b rt=%b",
                 VEC[i][15:12], i, lt_irq_n, rt_irq_n, VEC[i][1], VEC[i][0]);
      end
    end
    @(negedge clk); idle_ports();

    // R10 14-bit instance: 0x0FFF ignored, 0x3FFF raises the right side
    @(negedge clk);
    w_lt_addr = 14'h0FFF; w_lt_sel = 1; w_lt_wr = 1;
    @(posedge clk); #5;
    chk("R10 0x0FFF at 14 bits", w_rt_irq_n, 1'b1);
    @(negedge clk); w_lt_addr = 14'h3FFF;
    @(posedge clk); #5;
    chk("R10 0x3FFF at 14 bits", w_rt_irq_n, 1'b0);
    chk("R10 left side untouched", w_lt_irq_n, 1'b1);
    @(negedge clk); idle_ports();

    // R1 reset mid-operation: raise a flag, then reset
    @(negedge clk);
    rt_addr = code_addr(2'd1); rt_sel = 1; rt_wr = 1;
    @(posedge clk); #5;
    chk("R3 pre-reset set", lt_irq_n, 1'b0);
    @(negedge clk); idle_ports(); rst_n = 0;
    #5;
    chk("R1 lt mid reset", lt_irq_n, 1'b1);
    chk("R1 14-bit rt mid reset", w_rt_irq_n, 1'b1);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #5;
    chk("R1 lt after second release", lt_irq_n, 1'b1);

    finish_run();
  end
endmodule